// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a supervisory timer that sits on a simple 32-bit register bus. Software loads a 12-bit period value, picks an open-window size and a reaction, then arms the timer by writing a fixed key word to the control register. From then on the timer counts down once per clock from the scaled period. Arming is permanent until system reset.

To keep the system alive, software writes a two-word key sequence to the service register. The sequence only counts as good service while the counter is inside the open window, which is the last fraction of the period. A completed sequence that arrives before the window opens is a violation, and so is a counter that runs down to zero. On a violation the timer reloads, sets a sticky status flag and sends a one-cycle pulse on either its reset output or its non-maskable interrupt output.

All register reads return data one clock after the request. Register offsets are fixed because software addresses them directly.

Top module: `win_wdog_top`

## Requirements
- R1: After reset, both violation outputs are low and reads of control (0x90), status (0x98) and counter (0xA0) return 0; read data shows up on the cycle after a read request.
- R2: The period register (0x94) keeps only the low 12 bits of a write and returns them on read; the reload value is that field shifted left by 13.
- R3: Writing 0xA98559DA to control starts the timer with the counter at the reload value; control then reads back 0xA98559DA, while any other written value leaves the timer stopped and control reading 0.
- R4: Once started, the timer cannot be stopped, and writes to period, reaction (0xA4) and window (0xA8) have no effect on their contents until reset.
- R5: While running, the counter (readable at 0xA0) drops by one per clock; in the clock after it sits at zero it reloads and a violation is raised, so with no service the pulse appears 8193 clocks after a reload to 8192.
- R6: Writing 0xE51A then 0xA35C to the key register (0x9C) while the counter is inside the open window reloads the counter and raises no violation.
- R7: A key write that is neither 0xE51A nor the expected 0xA35C drops the sequence back to idle without reload; a lone 0xA35C from idle does nothing.
- R8: Window codes 0x50, 0x500, 0x5000, 0x50000, 0x500000 select open windows of 1/2, 1/4, 1/8, 1/16, 1/32 of the reload value (window open while counter < reload >> n); any other code acts as 0x50, and the window register reads back the code in effect.
- R9: A completed key sequence while the counter is at or above the window limit is a violation, and the counter still reloads.
- R10: Writing 0xA to the reaction register routes violations to the interrupt output; any other value routes them to the reset output; the register reads back 0xA or 0x5.
- R11: Each violation gives a pulse one clock wide, on exactly one of the two outputs, in the cycle after the violation.
- R12: Status bit 1 is set by each violation and stays set until a status write with bit 1 high clears it; a violation in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| wd_reset_o | output | 1 | One-cycle violation pulse, reset reaction |
| wd_nmi_o | output | 1 | One-cycle violation pulse, interrupt reaction |

## Verification
The configuration table walks every window code, an unlisted code, both reaction values and an oversized period write, which separates masked storage and code normalisation from raw storage. Service is tried early in the period, inside the widest and narrowest windows, as a broken sequence with a stray word, and not at all, so good service, early violation, ignored keys and expiry each show a different counter and pulse result. The two reaction settings tell the two output lines apart, and the exact expiry latency pins down the count length.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h90;
  localparam logic [7:0] OFS_PER   = 8'h94;
  localparam logic [7:0] OFS_STAT  = 8'h98;
  localparam logic [7:0] OFS_KEY   = 8'h9C;
  localparam logic [7:0] OFS_CNT   = 8'hA0;
  localparam logic [7:0] OFS_REACT = 8'hA4;
  localparam logic [7:0] OFS_WIN   = 8'hA8;

  localparam logic [31:0] ARM_WORD  = 32'hA98559DA;
  localparam logic [31:0] SVC_FIRST = 32'h0000E51A;
  localparam logic [31:0] SVC_LAST  = 32'h0000A35C;
  localparam logic [31:0] NMI_CODE  = 32'h0000000A;
  localparam logic [31:0] RST_CODE  = 32'h00000005;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_t;

  // Window code to right-shift amount applied to the reload value.
  function automatic logic [2:0] win_shift(input logic [31:0] code);
    case (code)
      32'h00000050: win_shift = 3'd1;
      32'h00000500: win_shift = 3'd2;
      32'h00005000: win_shift = 3'd3;
      32'h00050000: win_shift = 3'd4;
      32'h00500000: win_shift = 3'd5;
      default:      win_shift = 3'd1;
    endcase
  endfunction

  // Canonical code for a shift amount: 5 placed at nibble position sh.
  function automatic logic [31:0] win_code(input logic [2:0] sh);
    win_code = 32'h5 << {sh, 2'b00};
  endfunction

endpackage

// File: rtl/win_wdog_regs.sv
module win_wdog_regs
  import win_wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12,
  parameter int CNT_W  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              running,
  input  logic [CNT_W-1:0]  count,
  input  logic              violation,
  output logic [PRE_W-1:0]  period,
  output logic [2:0]        win_sh,
  output logic              nmi_sel,
  output logic              viol_flag,
  output logic              arm_req,
  output logic              key_wr,
  output logic [DATA_W-1:0] key_data
);

  logic wr, rd;
  logic sel_ctrl, sel_per, sel_stat, sel_key, sel_cnt, sel_react, sel_win;
  logic cfg_open;
  logic [DATA_W-1:0] rd_mux;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  assign sel_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
  assign sel_per   = bus_addr == ADDR_W'(OFS_PER);
  assign sel_stat  = bus_addr == ADDR_W'(OFS_STAT);
  assign sel_key   = bus_addr == ADDR_W'(OFS_KEY);
  assign sel_cnt   = bus_addr == ADDR_W'(OFS_CNT);
  assign sel_react = bus_addr == ADDR_W'(OFS_REACT);
  assign sel_win   = bus_addr == ADDR_W'(OFS_WIN);

  // Configuration is writable only before the timer is armed.
  assign cfg_open = wr & ~running;

  assign arm_req  = cfg_open & sel_ctrl & (bus_wdata == DATA_W'(ARM_WORD));
  assign key_wr   = wr & sel_key;
  assign key_data = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      period  <= '0;
      win_sh  <= 3'd1;
      nmi_sel <= 1'b0;
    end else if (cfg_open) begin
      if (sel_per)   period  <= bus_wdata[PRE_W-1:0];
      if (sel_win)   win_sh  <= win_shift(32'(bus_wdata));
      if (sel_react) nmi_sel <= bus_wdata == DATA_W'(NMI_CODE);
    end
  end

  // Sticky violation flag: set has priority over a write-one clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag <= 1'b0;
    end else if (violation) begin
      viol_flag <= 1'b1;
    end else if (wr && sel_stat && bus_wdata[1]) begin
      viol_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)  rd_mux = running ? DATA_W'(ARM_WORD) : '0;
    if (sel_per)   rd_mux = DATA_W'(period);
    if (sel_stat)  rd_mux = DATA_W'({viol_flag, 1'b0});
    if (sel_cnt)   rd_mux = DATA_W'(count);
    if (sel_react) rd_mux = nmi_sel ? DATA_W'(NMI_CODE) : DATA_W'(RST_CODE);
    if (sel_win)   rd_mux = DATA_W'(win_code(win_sh));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/win_wdog_keyseq.sv
module win_wdog_keyseq
  import win_wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              service
);

  key_state_t state, state_nx;
  logic       first_word, last_word;

  assign first_word = key_data == DATA_W'(SVC_FIRST);
  assign last_word  = key_data == DATA_W'(SVC_LAST);

  always_comb begin
    state_nx = state;
    service  = 1'b0;
    if (key_wr) begin
      if (first_word) begin
        state_nx = KS_ARMED;
      end else if (state == KS_ARMED && last_word) begin
        state_nx = KS_IDLE;
        service  = 1'b1;
      end else begin
        state_nx = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= KS_IDLE;
    else     state <= state_nx;
  end

endmodule

// File: rtl/win_wdog_core.sv
module win_wdog_core #(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  parameter int CNT_W = PRE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_req,
  input  logic             service,
  input  logic [PRE_W-1:0] period,
  input  logic [2:0]       win_sh,
  input  logic             nmi_sel,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             violation,
  output logic             wd_reset_o,
  output logic             wd_nmi_o
);

  logic [CNT_W-1:0] limit;
  logic             early, expire, at_zero;

  assign reload  = CNT_W'(period) << SHIFT;
  assign limit   = reload >> win_sh;
  assign at_zero = count == '0;

  assign early     = running & service & (count >= limit);
  assign expire    = running & ~service & at_zero;
  assign violation = early | expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count   <= '0;
    end else if (!running) begin
      if (arm_req) begin
        running <= 1'b1;
        count   <= reload;
      end
    end else if (service || at_zero) begin
      count <= reload;
    end else begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_reset_o <= 1'b0;
      wd_nmi_o   <= 1'b0;
    end else begin
      wd_reset_o <= violation & ~nmi_sel;
      wd_nmi_o   <= violation & nmi_sel;
    end
  end

endmodule

// File: rtl/win_wdog_top.sv
module win_wdog_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12,
  parameter int SHIFT  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_reset_o,
  output logic              wd_nmi_o
);

  localparam int CNT_W = PRE_W + SHIFT;

  logic              running, violation, viol_flag, nmi_sel;
  logic              arm_req, key_wr, svc;
  logic [CNT_W-1:0]  count, reload;
  logic [PRE_W-1:0]  period;
  logic [2:0]        win_sh;
  logic [DATA_W-1:0] key_data;

  win_wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .running(running), .count(count), .violation(violation),
    .period(period), .win_sh(win_sh), .nmi_sel(nmi_sel),
    .viol_flag(viol_flag), .arm_req(arm_req),
    .key_wr(key_wr), .key_data(key_data)
  );

  win_wdog_keyseq #(.DATA_W(DATA_W)) u_keys (
    .clk(clk), .rst(rst),
    .key_wr(key_wr), .key_data(key_data), .service(svc)
  );

  win_wdog_core #(.PRE_W(PRE_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .arm_req(arm_req), .service(svc),
    .period(period), .win_sh(win_sh), .nmi_sel(nmi_sel),
    .running(running), .count(count), .reload(reload),
    .violation(violation),
    .wd_reset_o(wd_reset_o), .wd_nmi_o(wd_nmi_o)
  );

endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_o,
  input logic             nmi_o,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             service,
  input logic             flag,
  input logic             violation
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> count == '0);

  assert_lock_R4: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  assert_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (running && !service && count != '0) |=> count == $past(count) - CNT_W'(1));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (running && service) |=> count == $past(reload));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    violation |=> $countones({rst_o, nmi_o}) == 1);

  assert_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (rst_o || nmi_o) |-> flag);

endmodule

bind win_wdog_top win_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rst_o(wd_reset_o), .nmi_o(wd_nmi_o),
  .running(running), .count(count), .reload(reload),
  .service(svc), .flag(viol_flag), .violation(violation)
);

// File: tb/tb_win_wdog_top.sv
module tb_win_wdog_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_reset_o, wd_nmi_o;

  int tests = 0;
  int fails = 0;
  int rst_seen = 0;
  int nmi_seen = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  win_wdog_top dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_reset_o(wd_reset_o), .wd_nmi_o(wd_nmi_o)
  );

  always @(negedge clk) begin
    if (wd_reset_o) rst_seen++;
    if (wd_nmi_o)   nmi_seen++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog timeout actual %0d expected <190000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [0:11] = '{
    {8'h94, 32'h00000123, 32'h00000123},
    {8'h94, 32'hFFFFFFF1, 32'h00000FF1},
    {8'hA8, 32'h00000500, 32'h00000500},
    {8'hA8, 32'h00005000, 32'h00005000},
    {8'hA8, 32'h00050000, 32'h00050000},
    {8'hA8, 32'h00500000, 32'h00500000},
    {8'hA8, 32'h00000007, 32'h00000050},
    {8'hA8, 32'h00000050, 32'h00000050},
    {8'hA4, 32'h0000000A, 32'h0000000A},
    {8'hA4, 32'h00000003, 32'h00000005},
    {8'h90, 32'h12345678, 32'h00000000},
    {8'h9C, 32'h0000E51A, 32'h00000000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int r0, n0, waitc;

    do_reset();
    // R1: reset state
    check(wd_reset_o == 1'b0 && wd_nmi_o == 1'b0, "R1", {30'b0, wd_reset_o, wd_nmi_o}, 0);
    rd(8'h90, v); check(v == 0, "R1", v, 0);
    rd(8'h98, v); check(v == 0, "R1", v, 0);
    rd(8'hA0, v); check(v == 0, "R1", v, 0);

    // Table walk: R2 masking, R8 window codes, R10 reaction, R3 bad enable
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check(v == VEC[i][31:0], "R2/R3/R8/R10 table", v, VEC[i][31:0]);
    end
    rd(8'hA0, v); check(v == 0, "R3 not started", v, 0);

    // Configure: period 1 (reload 8192), 50% window, reset reaction
    wr(8'h94, 32'h1);
    wr(8'hA8, 32'h50);
    wr(8'hA4, 32'h0);
    wr(8'h90, 32'hA98559DA);
    rd(8'h90, v); check(v == 32'hA98559DA, "R3", v, 32'hA98559DA);
    rd(8'hA0, v); check(v <= 8192 && v >= 8185, "R3 count start", v, 8192);

    // R9: early completed sequence is a violation; R11 one-cycle pulse
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    check(wd_reset_o == 1'b1 && wd_nmi_o == 1'b0, "R9", {30'b0, wd_reset_o, wd_nmi_o}, 32'h2);
    @(negedge clk);
    check(wd_reset_o == 1'b0, "R11", {31'b0, wd_reset_o}, 0);
    rd(8'hA0, v); check(v >= 8185 && v <= 8192, "R9 reload", v, 8192);
    // R12 sticky flag and clear
    rd(8'h98, v); check(v == 32'h2, "R12 set", v, 32'h2);
    wr(8'h98, 32'h1);
    rd(8'h98, v); check(v == 32'h2, "R12 bit0 no clear", v, 32'h2);
    wr(8'h98, 32'h2);
    rd(8'h98, v); check(v == 0, "R12 clear", v, 0);

    // R4: locked configuration
    wr(8'h94, 32'hFFF);
    rd(8'h94, v); check(v == 32'h1, "R4 period", v, 32'h1);
    wr(8'hA4, 32'hA);
    rd(8'hA4, v); check(v == 32'h5, "R4 reaction", v, 32'h5);
    wr(8'hA8, 32'h500000);
    rd(8'hA8, v); check(v == 32'h50, "R4 window", v, 32'h50);
    wr(8'h90, 32'h0);
    rd(8'h90, v); check(v == 32'hA98559DA, "R4 no disable", v, 32'hA98559DA);

    // R6: good service inside 50% window
    idle(4300);
    r0 = rst_seen;
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    rd(8'hA0, v); check(v >= 8185 && v <= 8192, "R6 reload", v, 8192);
    check(rst_seen == r0, "R6 no pulse", rst_seen, r0);

    // R7: broken sequence and lone last word do nothing
    idle(4300);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'h1111);
    wr(8'h9C, 32'hA35C);
    rd(8'hA0, v); check(v < 4096, "R7 no reload", v, 4096);
    check(rst_seen == r0, "R7 no pulse", rst_seen, r0);

    // R5: expiry raises reset pulse and status
    waitc = 0;
    while (!wd_reset_o && waitc < 6000) begin @(negedge clk); waitc++; end
    check(wd_reset_o == 1'b1, "R5 expiry", {31'b0, wd_reset_o}, 1);
    rd(8'h98, v); check(v == 32'h2, "R5/R12 status", v, 32'h2);

    // NMI reaction with 1/32 window (limit 256)
    do_reset();
    wr(8'h94, 32'h1);
    wr(8'hA8, 32'h500000);
    wr(8'hA4, 32'hA);
    wr(8'h90, 32'hA98559DA);
    idle(7000);
    r0 = rst_seen; n0 = nmi_seen;
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    check(wd_nmi_o == 1'b1 && wd_reset_o == 1'b0, "R10/R8 early nmi", {30'b0, wd_reset_o, wd_nmi_o}, 32'h1);
    @(negedge clk);
    check(wd_nmi_o == 1'b0, "R11 nmi width", {31'b0, wd_nmi_o}, 0);
    idle(7990);
    n0 = nmi_seen;
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    check(nmi_seen == n0 && rst_seen == r0, "R8 narrow window service", nmi_seen, n0);

    // R5: exact expiry latency after reload to 8192
    waitc = 0;
    while (!wd_nmi_o && waitc < 10000) begin @(negedge clk); waitc++; end
    check(waitc == 8193, "R5 latency", waitc, 8193);
    check(rst_seen == r0, "R10 no reset line", rst_seen, r0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule